// File: doc/BRIEF.md
# Banked Indirect Register Window

This block is the register-file front end of a PHY-style device. A management bus with a 5-bit address and 16-bit data reaches two kinds of storage. The first is a flat space of direct registers. The second is a set of banked register spaces, which are reached indirectly through three window registers: a control word, a staged write value and a captured read value. The bus is a parallel strobe interface, not a serial one.

To write into a bank, software first puts the value in the staging register. It then writes a control word that sets the write command bit and gives the bank number and the offset. To read from a bank, software writes a control word with the read command bit set, and the addressed word is copied into the capture register. Software then reads the capture register.

The block keeps track of the current bank. Moving into the DSP bank (number 4) from any other bank takes two control writes. The first one only switches the current bank. The second, identical one performs the access.

Top module: `bank_window_port`

## Requirements
- R1: After reset every direct register, every banked word, the staging register and the capture register read as zero, and the current bank is 0.
- R2: A bus write to address 0x16 loads the staging register, and a bus read of 0x16 returns the value last stored there.
- R3: A control write to address 0x14 with bit 11 set and bit 12 clear stores the staging value into the word selected by bank field bits 10:8 and offset field bits 7:0.
- R4: A control write with bit 12 set and bit 11 clear copies the selected banked word into the capture register, which reads back at address 0x15. The capture register changes on no other event.
- R5: Every control write loads the current bank from its bits 10:8. A read of 0x14 returns the current bank in bits 10:8 and zero in all other bits, so the command bits never read back as set.
- R6: A control write that names bank 4 while the current bank is not 4 only switches the current bank and moves no data. A second identical control write then performs the read or write.
- R7: A control write with both bits 12 and 11 set moves no data, but it still updates the current bank.
- R8: Window accesses to bank 0, to banks above the implemented count (5 to 7 by default), or to offsets at or beyond the bank depth discard writes and return zero to the capture register. Such accesses never alias onto a valid word.
- R9: Every direct address other than 0x14, 0x15 and 0x16 is a plain read/write register. Bus writes to 0x15 are ignored.
- R10: For every cycle with the read strobe high, the block returns the addressed value on the read data port one cycle later with the valid flag high. The valid flag stays low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 5 | Direct register address |
| wdata | input | 16 | Bus write data |
| rdata | output | 16 | Registered read data |
| rd_valid | output | 1 | High in the cycle after a read strobe |

## Verification
The bench builds the block with the default parameters: four implemented banks of sixteen words each.

With a depth of sixteen, offset 0x12 is out of range, while its low four bits point at offset 2, a word that the bench has already filled. This exposes any decode that wraps an out-of-range offset onto a valid word. With four implemented banks, the DSP bank is the highest implemented bank and banks 5 to 7 are unimplemented. The bench can therefore exercise the two-step DSP entry for both reads and writes, and also exercise the discard path.

// File: rtl/bwin_pkg.sv
package bwin_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int BANK_W   = 3;
  localparam int OFS_W    = 8;
  localparam int RD_BIT   = 12;
  localparam int WR_BIT   = 11;
  localparam int BANK_LSB = 8;
  localparam int CMD_W    = RD_BIT + 1;

  localparam logic [ADDR_W-1:0] A_CTL  = 5'h14;
  localparam logic [ADDR_W-1:0] A_RDAT = 5'h15;
  localparam logic [ADDR_W-1:0] A_WDAT = 5'h16;

  localparam logic [BANK_W-1:0] BANK_DSP = 3'd4;
endpackage

// File: rtl/bwin_bank_mem.sv
module bwin_bank_mem #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[widx] <= wdata;
    end
  end

  assign rdata = mem_q[ridx];
endmodule

// File: rtl/bwin_ctrl.sv
module bwin_ctrl
  import bwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CMD_W-1:0]  ctl_word,
  output logic [BANK_W-1:0] cur_bank,
  output logic              xfer_rd,
  output logic              xfer_wr,
  output logic [BANK_W-1:0] xfer_bank,
  output logic [OFS_W-1:0]  xfer_ofs
);
  logic              cmd_rd, cmd_wr, dsp_hold;
  logic [BANK_W-1:0] cmd_bank, bank_q, bank_d;

  assign cmd_rd   = ctl_word[RD_BIT];
  assign cmd_wr   = ctl_word[WR_BIT];
  assign cmd_bank = ctl_word[BANK_LSB +: BANK_W];

  // Entering the DSP bank from elsewhere only switches the bank.
  assign dsp_hold = (cmd_bank == BANK_DSP) && (bank_q != BANK_DSP);

  always_comb begin
    bank_d = bank_q;
    if (ctl_we) bank_d = cmd_bank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end

  assign xfer_rd   = ctl_we && !dsp_hold && cmd_rd && !cmd_wr;
  assign xfer_wr   = ctl_we && !dsp_hold && cmd_wr && !cmd_rd;
  assign xfer_bank = cmd_bank;
  assign xfer_ofs  = ctl_word[OFS_W-1:0];
  assign cur_bank  = bank_q;
endmodule

// File: rtl/bank_window_port.sv
module bank_window_port
  import bwin_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);
  localparam int IDX_W = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1;
  localparam int DIR_DEPTH = 1 << ADDR_W;

  logic              ctl_we, wdat_we, dir_we, ofs_ok;
  logic              xfer_rd, xfer_wr;
  logic [BANK_W-1:0] cur_bank, xfer_bank;
  logic [OFS_W-1:0]  xfer_ofs;
  logic [DATA_W-1:0] wdat_q, rdat_q, rdata_q, rdata_d, xfer_rdata, dir_rdata;
  logic              rvalid_q;
  logic [DATA_W-1:0] bank_rdata [NUM_BANKS];

  assign ctl_we  = wr_en && (addr == A_CTL);
  assign wdat_we = wr_en && (addr == A_WDAT);
  assign dir_we  = wr_en && (addr != A_CTL) && (addr != A_RDAT) && (addr != A_WDAT);

  bwin_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_we   (ctl_we),
    .ctl_word (wdata[CMD_W-1:0]),
    .cur_bank (cur_bank),
    .xfer_rd  (xfer_rd),
    .xfer_wr  (xfer_wr),
    .xfer_bank(xfer_bank),
    .xfer_ofs (xfer_ofs)
  );

  assign ofs_ok = int'(xfer_ofs) < BANK_DEPTH;

  for (genvar b = 1; b <= NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (xfer_bank == BANK_W'(b)) && ofs_ok;
    bwin_bank_mem #(.DEPTH(BANK_DEPTH), .DW(DATA_W)) u_mem (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (xfer_wr && sel),
      .widx (xfer_ofs[IDX_W-1:0]),
      .wdata(wdat_q),
      .ridx (xfer_ofs[IDX_W-1:0]),
      .rdata(bank_rdata[b-1])
    );
  end

  always_comb begin
    xfer_rdata = '0;
    for (int b = 1; b <= NUM_BANKS; b++) begin
      if ((xfer_bank == BANK_W'(b)) && ofs_ok) xfer_rdata = bank_rdata[b-1];
    end
  end

  bwin_bank_mem #(.DEPTH(DIR_DEPTH), .DW(DATA_W)) u_direct (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (dir_we),
    .widx (addr),
    .wdata(wdata),
    .ridx (addr),
    .rdata(dir_rdata)
  );

  always_comb begin
    rdata_d = dir_rdata;
    case (addr)
      A_CTL: begin
        rdata_d = '0;
        rdata_d[BANK_LSB +: BANK_W] = cur_bank;
      end
      A_RDAT:  rdata_d = rdat_q;
      A_WDAT:  rdata_d = wdat_q;
      default: rdata_d = dir_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdat_q   <= '0;
      rdat_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (wdat_we) wdat_q  <= wdata;
      if (xfer_rd) rdat_q  <= xfer_rdata;
      if (rd_en)   rdata_q <= rdata_d;
      rvalid_q <= rd_en;
    end
  end

  assign rdata    = rdata_q;
  assign rd_valid = rvalid_q;
endmodule

// File: rtl/bwin_checker.sv
module bwin_checker
  import bwin_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CMD_W-1:0]  wbits,
  input logic [BANK_W-1:0] cur_bank,
  input logic              xfer_rd,
  input logic              xfer_wr,
  input logic [DATA_W-1:0] rdat_q,
  input logic              rd_valid
);
  logic ctl_hit;
  logic [BANK_W-1:0] wbank;
  assign ctl_hit = wr_en && (addr == A_CTL);
  assign wbank   = wbits[BANK_LSB +: BANK_W];

  p_one_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_rd, xfer_wr}));

  p_capture_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_rd |=> $stable(rdat_q));

  p_bank_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_hit |=> (cur_bank == $past(wbank)));

  p_dsp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hit && wbank == BANK_DSP && cur_bank != BANK_DSP) |-> !(xfer_rd || xfer_wr));

  p_dsp_go_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hit && wbank == BANK_DSP && cur_bank == BANK_DSP && (wbits[RD_BIT] ^ wbits[WR_BIT]))
      |-> (xfer_rd || xfer_wr));

  p_both_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hit && wbits[RD_BIT] && wbits[WR_BIT]) |-> !(xfer_rd || xfer_wr));

  p_valid_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

bind bank_window_port bwin_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wbits   (wdata[bwin_pkg::CMD_W-1:0]),
  .cur_bank(cur_bank),
  .xfer_rd (xfer_rd),
  .xfer_wr (xfer_wr),
  .rdat_q  (rdat_q),
  .rd_valid(rd_valid)
);

// File: tb/bank_window_port_tb_top.sv
module bank_window_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [4:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        rd_valid;

  int checks = 0;
  int failures = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  bank_window_port dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid)
  );

  task automatic bus_wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // Monitor: pops expected items as results appear.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R10 unexpected valid: actual=%h expected=none", rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          failures++;
          $display("FAIL %s: actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R5 control view
    bus_rd(5'h14, 16'h0000, "R1 R5 ctl after reset");
    bus_rd(5'h15, 16'h0000, "R1 capture after reset");
    bus_rd(5'h16, 16'h0000, "R1 staging after reset");
    bus_rd(5'h03, 16'h0000, "R1 direct after reset");

    // R2 staging register
    bus_wr(5'h16, 16'hA5A5);
    bus_rd(5'h16, 16'hA5A5, "R2 staging readback");

    // R3 banked writes, R5 bank readback with command bits clear
    bus_wr(5'h14, 16'h0902);
    bus_rd(5'h14, 16'h0100, "R5 ctl shows bank 1");
    bus_wr(5'h16, 16'h1234);
    bus_wr(5'h14, 16'h0B0F);

    // R4 banked reads
    bus_wr(5'h14, 16'h1102);
    bus_rd(5'h15, 16'hA5A5, "R3 R4 bank1 ofs2");
    bus_wr(5'h14, 16'h130F);
    bus_rd(5'h15, 16'h1234, "R3 R4 bank3 ofs15");
    bus_wr(5'h14, 16'h1200);
    bus_rd(5'h15, 16'h0000, "R4 bank2 untouched");

    // R6 DSP entry for a write
    bus_wr(5'h16, 16'hBEEF);
    bus_wr(5'h14, 16'h0C05);
    bus_rd(5'h14, 16'h0400, "R6 bank switched to 4");
    bus_wr(5'h14, 16'h1405);
    bus_rd(5'h15, 16'h0000, "R6 first write held off");
    bus_wr(5'h14, 16'h0C05);
    bus_wr(5'h14, 16'h1405);
    bus_rd(5'h15, 16'hBEEF, "R6 second write done");

    // R6 DSP entry for a read
    bus_wr(5'h14, 16'h1102);
    bus_wr(5'h14, 16'h1405);
    bus_rd(5'h15, 16'hA5A5, "R6 first read held off");
    bus_wr(5'h14, 16'h1405);
    bus_rd(5'h15, 16'hBEEF, "R6 second read done");

    // R7 both command bits
    bus_wr(5'h16, 16'h7777);
    bus_wr(5'h14, 16'h1B02);
    bus_rd(5'h14, 16'h0300, "R7 bank updated");
    bus_rd(5'h15, 16'hBEEF, "R7 capture unchanged");
    bus_wr(5'h14, 16'h1302);
    bus_rd(5'h15, 16'h0000, "R7 no write happened");

    // R8 unimplemented bank, bank 0 via window, out-of-range offset
    bus_wr(5'h16, 16'h5555);
    bus_wr(5'h14, 16'h0D01);
    bus_wr(5'h14, 16'h130F);
    bus_wr(5'h14, 16'h1501);
    bus_rd(5'h15, 16'h0000, "R8 bank5 reads zero");
    bus_wr(5'h14, 16'h130F);
    bus_wr(5'h14, 16'h1003);
    bus_rd(5'h15, 16'h0000, "R8 bank0 via window zero");
    bus_wr(5'h14, 16'h0912);
    bus_wr(5'h14, 16'h1112);
    bus_rd(5'h15, 16'h0000, "R8 ofs 0x12 reads zero");
    bus_wr(5'h14, 16'h1102);
    bus_rd(5'h15, 16'hA5A5, "R8 no alias onto ofs2");

    // R9 direct registers
    bus_wr(5'h03, 16'hCAFE);
    bus_wr(5'h1F, 16'h0F0F);
    bus_rd(5'h03, 16'hCAFE, "R9 direct 0x03");
    bus_rd(5'h1F, 16'h0F0F, "R9 direct 0x1F");
    bus_wr(5'h15, 16'hFFFF);
    bus_rd(5'h15, 16'hA5A5, "R9 write to 0x15 ignored");

    // R10 drain and idle
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R10 missing results: actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule